// File: doc/BRIEF.md
# Hysteretic Frequency Lock Detector

This block decides whether a local oscillator is running at the frequency it should, relative to a reference. Both sources reach it as single-cycle enable strobes in the system clock domain. Over a measurement window of 2^WIN_LOG2 reference strobes it counts oscillator strobes. It compares that count with the count a perfect 2^n frequency ratio would give, where a 4-bit code selects n. The deviation is judged against two thresholds in parts per million, and a loss-of-lock flag follows them with hysteresis.

A history bit records every loss-of-lock event until software clears it. An output-mode select routes either the live flag or the history bit to the lock pin. A restart request forces a fresh acquisition: the flag is raised, the window in progress is thrown away, and the configuration inputs are left as they are. The clear and restart controls act when their bit falls, so software writes 1 and then 0.

Top module: `freq_lock_detector`

## Requirements
- R1: Out of reset the live loss-of-lock flag is 1, so `lol_out` is 1, and `sticky_lol` is 0.
- R2: A window closes on the 2^WIN_LOG2-th reference strobe after reset, restart or the previous window. Its count includes the oscillator strobe that arrives in the same cycle as that closing reference strobe.
- R3: At the close of a window the live flag goes to 1 when |count − E| · 10^6 > HI_PPM · E, where E = 2^(WIN_LOG2+n).
- R4: At the close of a window the live flag goes to 0 when |count − E| · 10^6 ≤ LO_PPM · E.
- R5: When the deviation lies between the two thresholds, the live flag keeps its previous value.
- R6: The live flag changes only on the clock edge after the cycle in which a window closes, or on a restart. Nothing in the middle of a window moves it.
- R7: `sticky_lol` goes to 1 on every 0→1 transition of the live flag, and it stays 1 after lock is regained.
- R8: `sticky_lol` is cleared on the clock edge that samples `sticky_clr` low after it was high. Holding `sticky_clr` high clears nothing. A new loss-of-lock event in that same cycle wins over the clear.
- R9: With `sticky_mode` = 1, `lol_out` shows `sticky_lol`. With `sticky_mode` = 0, it shows the live flag.
- R10: On the edge that samples `restart_req` low after it was high, the live flag goes to 1 and the partial window is discarded, so the next decision comes only after a full new window.
- R11: `ratio_code` n in 0..8 sets the expected ratio of oscillator to reference strobes to 2^n. Codes 9 to 15 act as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator period |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| ratio_code | input | 4 | Ratio exponent n (ratio 2^n, 9..15 treated as 8) |
| sticky_mode | input | 1 | 1: lock pin shows history bit; 0: live flag |
| sticky_clr | input | 1 | History clear control, acts on its falling edge |
| restart_req | input | 1 | Reacquisition control, acts on its falling edge |
| lol_out | output | 1 | Loss-of-lock pin |
| sticky_lol | output | 1 | Loss-of-lock history bit |

## Verification
The windows are built so that the deviation lands on each side of each threshold, with the oscillator both slow and fast: exactly on rate, 1, 2, 3, 4 and 5 counts off. This separates the strict comparison at the upper threshold from the inclusive one at the lower threshold, and shows that the hold region keeps both a 0 and a 1. One fast window hits the upper threshold only when the strobe that coincides with the closing reference strobe is counted. A restart in the middle of a window, followed by a full window, shows whether stale counts are carried over. Windows at ratio code 2 only pass or fail correctly if the expected count and thresholds are scaled by the code.

// File: rtl/fld_pkg.sv
// Shared constants and constant functions for the frequency lock detector.
// Assumes ppm thresholds and window exponents small enough for 64-bit math.
package fld_pkg;

    // Largest ratio exponent honoured; larger codes are clamped to this.
    localparam int unsigned MAX_CODE = 8;

    // Largest integer deviation that is still within ppm of 2^log2_exp counts.
    function automatic longint unsigned dev_limit(input int unsigned log2_exp,
                                                  input int unsigned ppm);
        longint unsigned scaled;
        scaled = longint'(ppm) << log2_exp;
        return scaled / 64'd1000000;
    endfunction

endpackage

// File: rtl/fld_window_counter.sv
// Measurement window counter: counts reference strobes up to 2^WIN_LOG2 and,
// in step with them, oscillator strobes. When the last reference strobe of a
// window arrives it latches the oscillator total, including a strobe in the
// same cycle, and pulses win_done for one cycle. A flush clears everything.
// Assumes strobes are synchronous one-cycle enables in the clk domain.
module fld_window_counter #(
    parameter int unsigned WIN_LOG2 = 20,
    parameter int unsigned CW       = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          osc_tick,
    input  logic          ref_tick,
    output logic          win_done,
    output logic [CW-1:0] win_count
);

    logic [WIN_LOG2-1:0] ref_cnt;
    logic [CW-1:0]       osc_cnt;
    logic [CW-1:0]       osc_next;
    logic                last_ref;

    // Saturating oscillator total including this cycle's strobe.
    assign osc_next = (&osc_cnt) ? osc_cnt : osc_cnt + CW'(osc_tick);
    assign last_ref = ref_tick && (&ref_cnt);

    // Advance both counters, close the window on the final reference strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ref_cnt   <= '0;
            osc_cnt   <= '0;
            win_done  <= 1'b0;
            win_count <= '0;
        end else begin
            win_done <= last_ref;
            if (ref_tick) begin
                ref_cnt <= ref_cnt + 1'b1;
            end
            if (last_ref) begin
                win_count <= osc_next;
                osc_cnt   <= '0;
            end else begin
                osc_cnt <= osc_next;
            end
        end
    end

endmodule

// File: rtl/fld_error_judge.sv
// Deviation judge: compares a window count with the ideal count
// 2^(WIN_LOG2+n) and reports whether the deviation exceeds the upper ppm
// threshold or lies within the lower one. The thresholds are precomputed
// per code as integer count limits. Purely combinational.
module fld_error_judge
    import fld_pkg::*;
#(
    parameter int unsigned WIN_LOG2 = 20,
    parameter int unsigned CW       = 30,
    parameter int unsigned HI_PPM   = 1000,
    parameter int unsigned LO_PPM   = 250
) (
    input  logic [3:0]    ratio_code,
    input  logic [CW-1:0] win_count,
    output logic          too_far,
    output logic          close_enough
);

    localparam int unsigned NC = MAX_CODE + 1;

    logic [CW-1:0] expect_tab [NC];
    logic [CW-1:0] hi_tab     [NC];
    logic [CW-1:0] lo_tab     [NC];
    logic [3:0]    code_eff;
    logic [CW-1:0] expect_cnt;
    logic [CW-1:0] dev;

    // One constant entry per supported ratio exponent.
    for (genvar g = 0; g < NC; g++) begin : g_tab
        assign expect_tab[g] = CW'(1) << (WIN_LOG2 + g);
        assign hi_tab[g]     = CW'(dev_limit(WIN_LOG2 + g, HI_PPM));
        assign lo_tab[g]     = CW'(dev_limit(WIN_LOG2 + g, LO_PPM));
    end

    // Clamp the code, form the absolute deviation and compare both limits.
    always_comb begin
        code_eff     = (ratio_code > 4'(MAX_CODE)) ? 4'(MAX_CODE) : ratio_code;
        expect_cnt   = expect_tab[code_eff];
        dev          = (win_count >= expect_cnt) ? win_count - expect_cnt
                                                 : expect_cnt - win_count;
        too_far      = dev > hi_tab[code_eff];
        close_enough = dev <= lo_tab[code_eff];
    end

endmodule

// File: rtl/fld_lock_state.sv
// Lock state: keeps the hysteretic live loss-of-lock flag and the sticky
// history bit, and selects which of them drives the lock pin. Assumes the
// judge outputs are valid in the cycle win_done is high.
module fld_lock_state (
    input  logic clk,
    input  logic rst_n,
    input  logic win_done,
    input  logic too_far,
    input  logic close_enough,
    input  logic restart_fall,
    input  logic clr_fall,
    input  logic sticky_mode,
    output logic lol_live,
    output logic sticky_lol,
    output logic lol_out
);

    logic live_next;

    // Next live flag: restart forces it, a window decides it, else hold.
    always_comb begin
        live_next = lol_live;
        if (restart_fall) begin
            live_next = 1'b1;
        end else if (win_done) begin
            if (too_far) begin
                live_next = 1'b1;
            end else if (close_enough) begin
                live_next = 1'b0;
            end
        end
    end

    // Register the live flag and update the history bit (a set beats a clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lol_live   <= 1'b1;
            sticky_lol <= 1'b0;
        end else begin
            lol_live <= live_next;
            if (live_next && !lol_live) begin
                sticky_lol <= 1'b1;
            end else if (clr_fall) begin
                sticky_lol <= 1'b0;
            end
        end
    end

    assign lol_out = sticky_mode ? sticky_lol : lol_live;

endmodule

// File: rtl/freq_lock_detector.sv
// Top of the hysteretic frequency lock detector. Detects falling edges of
// the clear and restart controls, flushes the window on restart, and ties
// together the window counter, the deviation judge and the lock state.
// Assumes all inputs are synchronous to clk.
module freq_lock_detector
    import fld_pkg::*;
#(
    parameter int unsigned WIN_LOG2 = 20,
    parameter int unsigned HI_PPM   = 1000,
    parameter int unsigned LO_PPM   = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       ref_tick,
    input  logic [3:0] ratio_code,
    input  logic       sticky_mode,
    input  logic       sticky_clr,
    input  logic       restart_req,
    output logic       lol_out,
    output logic       sticky_lol
);

    localparam int unsigned CW = WIN_LOG2 + MAX_CODE + 2;

    logic          restart_q;
    logic          clr_q;
    logic          restart_fall;
    logic          clr_fall;
    logic          win_done;
    logic [CW-1:0] win_count;
    logic          too_far;
    logic          close_enough;
    logic          lol_live;

    // Remember the previous control levels for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
            clr_q     <= 1'b0;
        end else begin
            restart_q <= restart_req;
            clr_q     <= sticky_clr;
        end
    end

    assign restart_fall = restart_q && !restart_req;
    assign clr_fall     = clr_q && !sticky_clr;

    fld_window_counter #(
        .WIN_LOG2 (WIN_LOG2),
        .CW       (CW)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (restart_fall),
        .osc_tick  (osc_tick),
        .ref_tick  (ref_tick),
        .win_done  (win_done),
        .win_count (win_count)
    );

    fld_error_judge #(
        .WIN_LOG2 (WIN_LOG2),
        .CW       (CW),
        .HI_PPM   (HI_PPM),
        .LO_PPM   (LO_PPM)
    ) u_judge (
        .ratio_code   (ratio_code),
        .win_count    (win_count),
        .too_far      (too_far),
        .close_enough (close_enough)
    );

    fld_lock_state u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .win_done     (win_done),
        .too_far      (too_far),
        .close_enough (close_enough),
        .restart_fall (restart_fall),
        .clr_fall     (clr_fall),
        .sticky_mode  (sticky_mode),
        .lol_live     (lol_live),
        .sticky_lol   (sticky_lol),
        .lol_out      (lol_out)
    );

endmodule

// File: rtl/fld_checker.sv
// Property checker for the frequency lock detector, bound to the top.
module fld_checker (
    input logic clk,
    input logic rst_n,
    input logic restart_req,
    input logic sticky_clr,
    input logic lol_live,
    input logic sticky_lol,
    input logic win_done
);

    // R10
    restart_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(restart_req) |=> lol_live);

    // R7
    event_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lol_live) |-> sticky_lol);

    // R7
    sticky_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sticky_lol) && !$past($fell(sticky_clr)) && !$past(!rst_n) |-> sticky_lol);

    // R8
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sticky_clr) |=> (!sticky_lol || $rose(lol_live)));

    // R6
    flag_moves_on_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lol_live) && !$past(!rst_n) |-> ($past(win_done) || $past($fell(restart_req))));

endmodule

bind freq_lock_detector fld_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_req (restart_req),
    .sticky_clr  (sticky_clr),
    .lol_live    (lol_live),
    .sticky_lol  (sticky_lol),
    .win_done    (win_done)
);

// File: tb/freq_lock_detector_tb.sv
// Bench: behavioural reference model compared every cycle, plus directed
// checks on each requirement. Window shortened to 2^12 reference strobes.
module freq_lock_detector_tb;

    localparam int W      = 12;
    localparam int HI_PPM = 1000;
    localparam int LO_PPM = 250;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       ref_tick = 1'b0;
    logic [3:0] ratio_code = 4'd0;
    logic       sticky_mode = 1'b0;
    logic       sticky_clr = 1'b0;
    logic       restart_req = 1'b0;
    logic       lol_out;
    logic       sticky_lol;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    freq_lock_detector #(.WIN_LOG2(W), .HI_PPM(HI_PPM), .LO_PPM(LO_PPM)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_tick    (osc_tick),
        .ref_tick    (ref_tick),
        .ratio_code  (ratio_code),
        .sticky_mode (sticky_mode),
        .sticky_clr  (sticky_clr),
        .restart_req (restart_req),
        .lol_out     (lol_out),
        .sticky_lol  (sticky_lol)
    );

    // Reference model state
    int     m_ref, m_osc, m_pcnt;
    bit     m_pv, m_live, m_sticky, m_rq, m_cq;

    always @(posedge clk) begin
        bit     rf, cf, nl;
        int     n;
        longint e, d;
        if (!rst_n) begin
            m_ref = 0; m_osc = 0; m_pcnt = 0; m_pv = 0;
            m_live = 1; m_sticky = 0; m_rq = 0; m_cq = 0;
        end else begin
            rf = m_rq && !restart_req;
            cf = m_cq && !sticky_clr;
            nl = m_live;
            if (rf) nl = 1;
            else if (m_pv) begin
                n = (ratio_code > 8) ? 8 : int'(ratio_code);
                e = longint'(1) << (W + n);
                d = (m_pcnt > e) ? m_pcnt - e : e - m_pcnt;
                if (d * 1000000 > HI_PPM * e) nl = 1;
                else if (d * 1000000 <= LO_PPM * e) nl = 0;
            end
            if (nl && !m_live) m_sticky = 1;
            else if (cf) m_sticky = 0;
            m_live = nl;
            if (rf) begin
                m_ref = 0; m_osc = 0; m_pv = 0;
            end else begin
                m_pv = ref_tick && (m_ref == (1 << W) - 1);
                if (m_pv) begin
                    m_pcnt = m_osc + int'(osc_tick);
                    m_osc = 0; m_ref = 0;
                end else begin
                    m_osc += int'(osc_tick);
                    if (ref_tick) m_ref++;
                end
            end
            m_rq = restart_req;
            m_cq = sticky_clr;
        end
    end

    // Every-cycle comparison against the model (R9 output select, R7 history).
    always @(negedge clk) begin
        if (rst_n) begin
            tests++;
            if (lol_out !== (sticky_mode ? m_sticky : m_live)) begin
                fails++;
                $display("FAIL R9 model lol_out act=%0b exp=%0b t=%0t", lol_out,
                         sticky_mode ? m_sticky : m_live, $time);
            end
            tests++;
            if (sticky_lol !== m_sticky) begin
                fails++;
                $display("FAIL R7 model sticky_lol act=%0b exp=%0b t=%0t", sticky_lol, m_sticky, $time);
            end
        end
    end

    task automatic check(input logic act, input logic exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            osc_tick = 1'b0;
            ref_tick = 1'b0;
        end
    endtask

    // One full window: ref strobe every per cycles minus the first ref_skip,
    // osc strobe every cycle minus the first osc_skip.
    task automatic run_window(input int osc_skip, input int ref_skip, input int per);
        int refs = 0;
        int i = 0;
        while (refs < (1 << W)) begin
            @(negedge clk);
            osc_tick = (i >= osc_skip);
            ref_tick = ((i % per) == 0) && ((i / per) >= ref_skip);
            if (ref_tick) refs++;
            i++;
        end
        idle(3);
    endtask

    task automatic run_both(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            osc_tick = 1'b1;
            ref_tick = 1'b1;
        end
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(lol_out, 1'b1, "R1 reset lol_out");
        check(sticky_lol, 1'b0, "R1 reset sticky");

        // Code 0: E=4096, upper limit dev>4, lower limit dev<=1
        run_window(0, 0, 1);
        check(lol_out, 1'b0, "R4 exact window locks");
        check(sticky_lol, 1'b0, "R7 no event on lock");
        run_window(3, 0, 1);
        check(lol_out, 1'b0, "R5 dev3 slow holds 0");
        run_window(5, 0, 1);
        check(lol_out, 1'b1, "R3 dev5 slow asserts");
        check(sticky_lol, 1'b1, "R7 event sets sticky");
        run_window(2, 0, 1);
        check(lol_out, 1'b1, "R5 dev2 holds 1");
        run_window(0, 1, 1);
        check(lol_out, 1'b0, "R4 dev1 fast deasserts");
        run_window(0, 4, 1);
        check(lol_out, 1'b0, "R3 dev4 fast at limit holds");
        run_window(0, 5, 1);
        check(lol_out, 1'b1, "R2 R3 dev5 fast counts coincident strobe");
        run_window(0, 0, 1);
        check(lol_out, 1'b0, "R4 relock");
        check(sticky_lol, 1'b1, "R7 sticky survives relock");

        // Output select and clear
        @(negedge clk); sticky_mode = 1'b1;
        @(negedge clk);
        check(lol_out, 1'b1, "R9 sticky routed to pin");
        sticky_clr = 1'b1;
        idle(5);
        check(sticky_lol, 1'b1, "R8 high level does not clear");
        sticky_clr = 1'b0;
        idle(2);
        check(sticky_lol, 1'b0, "R8 falling edge clears");
        check(lol_out, 1'b0, "R9 pin follows cleared sticky");
        sticky_mode = 1'b0;
        idle(1);
        check(lol_out, 1'b0, "R9 live routed to pin");

        // Restart mid-window, partial discarded
        run_both(2000);
        idle(1);
        restart_req = 1'b1;
        idle(2);
        check(lol_out, 1'b0, "R10 restart high level no effect");
        restart_req = 1'b0;
        idle(2);
        check(lol_out, 1'b1, "R10 restart forces lol");
        check(sticky_lol, 1'b1, "R7 restart is an event");
        run_both((1 << W) - 1);
        idle(3);
        check(lol_out, 1'b1, "R6 R10 no decision before full window");
        run_both(1);
        idle(3);
        check(lol_out, 1'b0, "R6 R10 decision after full window");

        // Code 2: E=16384, upper limit dev>16, lower limit dev<=4
        ratio_code = 4'd2;
        run_window(20, 0, 4);
        check(lol_out, 1'b1, "R11 code2 dev23 asserts");
        run_window(0, 0, 4);
        check(lol_out, 1'b0, "R11 code2 dev3 deasserts");

        finish_run();
    end

endmodule